// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block translates a 32-bit effective address through segment registers and a hashed page table in memory. It is used when a fast block translation has missed. On a start pulse it picks a segment register with the top address nibble, forms a protection key from the privilege state, and derives a primary page-table group address from the virtual segment identifier, the page index and a table descriptor that gives the table base and size. It then reads the group's entries one by one over a simple request/acknowledge memory bus.

If no entry in the primary group grants the access, the same search runs over the secondary group. When an entry matches and grants the access, the block returns the physical page, the read/write permissions and a hit status. It also writes the entry's second word back with the referenced bit set, and with the changed bit set for a write, when that update alters the word. Segments marked direct-store are only reported. Instruction fetches from no-execute segments are refused. Neither case makes any memory access.

Top module: `hpt_search`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low.
- R2: The segment register is `seg_regs[32*s +: 32]` with s = `ea[31:28]`. When its bit 31 is set, the search ends with status 4 (direct-store), zero permissions and no memory access.
- R3: An instruction fetch (`is_fetch`=1) from a segment with bit 28 set, and bit 31 clear, ends with status 3 (no-execute) and no memory access.
- R4: With VSID = segment bits 23:0 and page index P = `ea[27:12]`, the primary hash is H1 = ((VSID xor P) and 0x7FFFF) << 6. The group address is (desc and 0xFFFF0000) or (H and ((desc[8:0] << 16) or 0xFFC0)). Entry k is read at group + 8k. Its first word is `mem_rdata[63:32]` and its second word is `mem_rdata[31:0]`.
- R5: An entry is a candidate when first-word bit 31 is 1 and bit 6 equals the pass (0 primary, 1 secondary). A candidate matches when (first word and 0x7FFFFFBF) equals (VSID << 7) or P[15:10].
- R6: The secondary pass uses H2 = (not H1) and 0x01FFFFC0 through the same mask. It runs only when the primary pass found no matching entry that grants the access. A granted match ends the search at once.
- R7: The key is 1 when (segment bit 29 and user) or (segment bit 30 and supervisor). With PP = second word bits 1:0: for key 0, PP 00/01/10 give read/write and 11 gives read-only. For key 1, 00 gives nothing, 01/11 give read-only and 10 gives read/write. A write needs write permission and a read needs read permission.
- R8: After both passes with no grant, the status is 2 (protection) if any entry matched, else 1 (not found). Permissions are zero in both cases.
- R9: On a grant the status is 0. `phys_addr` is second word bits 31:12 followed by `ea[11:0]`, and `perm_rd`/`perm_wr` show the PP rights.
- R10: On a grant the new second word is the old one with bit 8 set, and with bit 7 also set for a write. It is written to entry address + 4 only when it differs from the old word.
- R11: `mem_req` stays high with a stable address and direction until `mem_ack`. `done` is a one-cycle pulse. `start` is ignored while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (idle only) |
| ea | input | 32 | Effective address |
| is_write | input | 1 | Access is a store |
| is_fetch | input | 1 | Access is an instruction fetch |
| user_mode | input | 1 | 1 = user state, 0 = supervisor |
| seg_regs | input | 512 | Sixteen 32-bit segment registers, register s at bits 32s+31:32s |
| tbl_desc | input | 32 | Table descriptor: base in 31:16, size field in 8:0 |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 hit, 1 not found, 2 protection, 3 no-execute, 4 direct-store |
| phys_addr | output | 32 | Translated physical address (valid on hit) |
| perm_rd | output | 1 | Page readable |
| perm_wr | output | 1 | Page writable |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a 32-bit write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data (updated second word) |
| mem_rdata | input | 64 | Read data, first word in the upper half |
| mem_ack | input | 1 | Request completed |

## Verification
The bench builds the block with its default of eight entries per group. It uses two table descriptors, one with a zero size field and one with a nonzero size field, so that high hash bits reach the group address. Entries are placed where the bench's own hash arithmetic says they belong, with decoys that are invalid, carry the wrong pass bit or have denied rights. This exercises a late-slot primary hit, a secondary hit, a full 16-read miss and protection results under both keys. Memory read and write counts are compared, which shows that the early-exit cases make no bus traffic and that unchanged entries are not written back.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int AW       = 32;
  localparam int SEG_W    = 32;
  localparam int SEL_W    = 4;
  localparam int SEG_NUM  = 1 << SEL_W;
  localparam int PIDX_W   = 16;
  localparam int OFF_W    = 12;
  localparam int ENT_LOG2 = 3;

  typedef enum logic [2:0] {
    ST_HIT    = 3'd0,
    ST_NOFIND = 3'd1,
    ST_PROT   = 3'd2,
    ST_NOEXEC = 3'd3,
    ST_DIRECT = 3'd4
  } res_t;
endpackage

// File: rtl/hpt_hash_calc.sv
module hpt_hash_calc
  import hpt_pkg::*;
(
  input  logic [SEG_W-1:0]  seg,
  input  logic [PIDX_W-1:0] pidx,
  input  logic [15:0]       tbl_base,
  input  logic [8:0]        tbl_size,
  input  logic              user_mode,
  output logic              key,
  output logic              direct_seg,
  output logic              noexec_seg,
  output logic [AW-1:0]     grp_pri,
  output logic [AW-1:0]     grp_sec,
  output logic [AW-1:0]     ptem
);
  logic [23:0]   vsid;
  logic [AW-1:0] mix, h1, h2, mask, base;
  logic          unused_seg_bits;

  assign unused_seg_bits = ^seg[27:24];

  always_comb begin
    vsid       = seg[23:0];
    key        = (seg[29] & user_mode) | (seg[30] & ~user_mode);
    direct_seg = seg[31];
    noexec_seg = seg[28];
    mix        = {8'h00, vsid ^ {8'h00, pidx}};
    h1         = (mix & 32'h0007_FFFF) << 6;
    h2         = ~h1 & 32'h01FF_FFC0;
    mask       = {7'b0, tbl_size, 16'hFFC0};
    base       = {tbl_base, 16'h0000};
    grp_pri    = base | (h1 & mask);
    grp_sec    = base | (h2 & mask);
    ptem       = {1'b0, vsid, 1'b0, pidx[15:10]};
  end
endmodule

// File: rtl/hpt_prot_eval.sv
module hpt_prot_eval (
  input  logic       key,
  input  logic [1:0] pp,
  input  logic       is_write,
  output logic       can_rd,
  output logic       can_wr,
  output logic       grant
);
  always_comb begin
    if (!key) begin
      can_rd = 1'b1;
      can_wr = (pp != 2'b11);
    end else begin
      can_rd = (pp != 2'b00);
      can_wr = (pp == 2'b10);
    end
    grant = is_write ? can_wr : can_rd;
  end
endmodule

// File: rtl/hpt_walk_ctrl.sv
module hpt_walk_ctrl
  import hpt_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic             is_fetch,
  input  logic [OFF_W-1:0] off,
  input  logic             key,
  input  logic             direct_seg,
  input  logic             noexec_seg,
  input  logic [AW-1:0]    grp_pri,
  input  logic [AW-1:0]    grp_sec,
  input  logic [AW-1:0]    ptem,
  output logic             key_q,
  output logic             wr_q,
  output logic [1:0]       pp,
  input  logic             can_rd,
  input  logic             can_wr,
  input  logic             grant,
  output logic             busy,
  output logic             done,
  output logic [2:0]       status,
  output logic [AW-1:0]    phys_addr,
  output logic             perm_rd,
  output logic             perm_wr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [63:0]      mem_rdata,
  input  logic             mem_ack
);
  localparam int IDX_W = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_EVAL, S_WR, S_FIN} st_t;

  st_t              st_q, st_d;
  logic             pass_q, pass_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [63:0]      ent_q;
  logic             ent_en;
  logic             seen_q, seen_d;
  logic [2:0]       stat_q, stat_d;
  logic [AW-1:0]    phys_q, phys_d;
  logic             prd_q, prd_d, pwr_q, pwr_d;
  logic [31:0]      wdat_q, wdat_d;
  logic             lat_en;
  logic             wr_l, key_l;
  logic [OFF_W-1:0] off_q;
  logic [AW-1:0]    gp_q, gs_q, ptem_q;

  logic [31:0]      w0, w1, w1_new;
  logic             match;
  logic [AW-1:0]    ent_addr;

  assign w0       = ent_q[63:32];
  assign w1       = ent_q[31:0];
  assign pp       = w1[1:0];
  assign key_q    = key_l;
  assign wr_q     = wr_l;
  assign match    = w0[31] && (w0[6] == pass_q) &&
                    ((w0 & 32'h7FFF_FFBF) == ptem_q);
  assign w1_new   = w1 | 32'h0000_0100 | (wr_l ? 32'h0000_0080 : 32'h0);
  assign ent_addr = (pass_q ? gs_q : gp_q) + (AW'(idx_q) << ENT_LOG2);

  assign lat_en   = (st_q == S_IDLE) && start;
  assign ent_en   = (st_q == S_RD) && mem_ack;

  always_comb begin
    st_d   = st_q;
    pass_d = pass_q;
    idx_d  = idx_q;
    seen_d = seen_q;
    stat_d = stat_q;
    phys_d = phys_q;
    prd_d  = prd_q;
    pwr_d  = pwr_q;
    wdat_d = wdat_q;
    unique case (st_q)
      S_IDLE: if (start) begin
        pass_d = 1'b0;
        idx_d  = '0;
        seen_d = 1'b0;
        prd_d  = 1'b0;
        pwr_d  = 1'b0;
        phys_d = '0;
        if (direct_seg) begin
          stat_d = ST_DIRECT;
          st_d   = S_FIN;
        end else if (is_fetch && noexec_seg) begin
          stat_d = ST_NOEXEC;
          st_d   = S_FIN;
        end else begin
          st_d = S_RD;
        end
      end
      S_RD: if (mem_ack) st_d = S_EVAL;
      S_EVAL: begin
        if (match && grant) begin
          stat_d = ST_HIT;
          phys_d = {w1[31:OFF_W], off_q};
          prd_d  = can_rd;
          pwr_d  = can_wr;
          wdat_d = w1_new;
          st_d   = (w1_new != w1) ? S_WR : S_FIN;
        end else begin
          seen_d = seen_q | match;
          if (idx_q == LAST_IDX) begin
            if (!pass_q) begin
              pass_d = 1'b1;
              idx_d  = '0;
              st_d   = S_RD;
            end else begin
              stat_d = (seen_q | match) ? ST_PROT : ST_NOFIND;
              st_d   = S_FIN;
            end
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = S_RD;
          end
        end
      end
      S_WR:  if (mem_ack) st_d = S_FIN;
      S_FIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pass_q <= 1'b0;
      idx_q  <= '0;
      seen_q <= 1'b0;
      stat_q <= 3'd0;
      phys_q <= '0;
      prd_q  <= 1'b0;
      pwr_q  <= 1'b0;
      wdat_q <= '0;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
      idx_q  <= idx_d;
      seen_q <= seen_d;
      stat_q <= stat_d;
      phys_q <= phys_d;
      prd_q  <= prd_d;
      pwr_q  <= pwr_d;
      wdat_q <= wdat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (ent_en) begin
      ent_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_l   <= 1'b0;
      key_l  <= 1'b0;
      off_q  <= '0;
      gp_q   <= '0;
      gs_q   <= '0;
      ptem_q <= '0;
    end else if (lat_en) begin
      wr_l   <= is_write;
      key_l  <= key;
      off_q  <= off;
      gp_q   <= grp_pri;
      gs_q   <= grp_sec;
      ptem_q <= ptem;
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_FIN);
  assign status    = stat_q;
  assign phys_addr = phys_q;
  assign perm_rd   = prd_q;
  assign perm_wr   = pwr_q;
  assign mem_req   = (st_q == S_RD) || (st_q == S_WR);
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = (st_q == S_WR) ? (ent_addr + AW'(4)) : ent_addr;
  assign mem_wdata = wdat_q;
endmodule

// File: rtl/hpt_search.sv
module hpt_search
  import hpt_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [AW-1:0]          ea,
  input  logic                   is_write,
  input  logic                   is_fetch,
  input  logic                   user_mode,
  input  logic [SEG_NUM*SEG_W-1:0] seg_regs,
  input  logic [31:0]            tbl_desc,
  output logic                   busy,
  output logic                   done,
  output logic [2:0]             status,
  output logic [AW-1:0]          phys_addr,
  output logic                   perm_rd,
  output logic                   perm_wr,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [31:0]            mem_wdata,
  input  logic [63:0]            mem_rdata,
  input  logic                   mem_ack
);
  logic [SEG_W-1:0] seg_sel;
  logic             key, direct_seg, noexec_seg;
  logic [AW-1:0]    grp_pri, grp_sec, ptem;
  logic             key_q, wr_q, can_rd, can_wr, grant;
  logic [1:0]       pp;
  logic             unused_desc_bits;

  assign unused_desc_bits = ^tbl_desc[15:9];
  assign seg_sel = seg_regs[SEG_W*ea[AW-1 -: SEL_W] +: SEG_W];

  hpt_hash_calc u_hash (
    .seg        (seg_sel),
    .pidx       (ea[OFF_W +: PIDX_W]),
    .tbl_base   (tbl_desc[31:16]),
    .tbl_size   (tbl_desc[8:0]),
    .user_mode  (user_mode),
    .key        (key),
    .direct_seg (direct_seg),
    .noexec_seg (noexec_seg),
    .grp_pri    (grp_pri),
    .grp_sec    (grp_sec),
    .ptem       (ptem)
  );

  hpt_prot_eval u_prot (
    .key      (key_q),
    .pp       (pp),
    .is_write (wr_q),
    .can_rd   (can_rd),
    .can_wr   (can_wr),
    .grant    (grant)
  );

  hpt_walk_ctrl #(.GROUP_ENTRIES(GROUP_ENTRIES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .is_write   (is_write),
    .is_fetch   (is_fetch),
    .off        (ea[OFF_W-1:0]),
    .key        (key),
    .direct_seg (direct_seg),
    .noexec_seg (noexec_seg),
    .grp_pri    (grp_pri),
    .grp_sec    (grp_sec),
    .ptem       (ptem),
    .key_q      (key_q),
    .wr_q       (wr_q),
    .pp         (pp),
    .can_rd     (can_rd),
    .can_wr     (can_wr),
    .grant      (grant),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .phys_addr  (phys_addr),
    .perm_rd    (perm_rd),
    .perm_wr    (perm_wr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack)
  );
endmodule

// File: rtl/hpt_search_chk.sv
module hpt_search_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [2:0]  status,
  input logic        perm_rd,
  input logic        perm_wr,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);
  p_idle_no_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_rd_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[2:0] == 3'd0));

  p_wb_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[8] && mem_addr[2:0] == 3'd4));

  p_hit_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd0) |-> perm_rd);

  p_miss_noperm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 3'd0) |-> (!perm_rd && !perm_wr));
endmodule

bind hpt_search hpt_search_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .status    (status),
  .perm_rd   (perm_rd),
  .perm_wr   (perm_wr),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/hpt_search_tb_top.sv
module hpt_search_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  ea = '0;
  logic         is_write = 1'b0;
  logic         is_fetch = 1'b0;
  logic         user_mode = 1'b0;
  logic [511:0] seg_regs = '0;
  logic [31:0]  tbl_desc = 32'h0010_0000;
  logic         busy, done, perm_rd, perm_wr, mem_req, mem_we;
  logic [2:0]   status;
  logic [31:0]  phys_addr, mem_addr, mem_wdata;
  logic [63:0]  mem_rdata = '0;
  logic         mem_ack = 1'b0;

  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [31:0] last_wa = '0;
  logic [31:0] last_wd = '0;
  logic [63:0] mem [bit [31:0]];

  always #5 clk = ~clk;

  hpt_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .is_write(is_write),
    .is_fetch(is_fetch), .user_mode(user_mode), .seg_regs(seg_regs),
    .tbl_desc(tbl_desc), .busy(busy), .done(done), .status(status),
    .phys_addr(phys_addr), .perm_rd(perm_rd), .perm_wr(perm_wr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        bit [31:0] a;
        a = {mem_addr[31:3], 3'b000};
        if (mem.exists(a)) mem[a] = {mem[a][63:32], mem_wdata};
        else mem[a] = {32'h0, mem_wdata};
        wr_cnt  <= wr_cnt + 1;
        last_wa <= mem_addr;
        last_wd <= mem_wdata;
      end else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
        rd_cnt    <= rd_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] grp_of(input logic [31:0] seg, input logic [31:0] va,
                                         input logic [31:0] desc, input bit sec);
    logic [31:0] x, h, m;
    x = ({8'h0, seg[23:0]} ^ {16'h0, va[27:12]}) & 32'h0007_FFFF;
    h = x << 6;
    if (sec) h = (~h) & 32'h01FF_FFC0;
    m = ({23'h0, desc[8:0]} << 16) | 32'h0000_FFC0;
    return (desc & 32'hFFFF_0000) | (h & m);
  endfunction

  function automatic logic [31:0] tag_of(input logic [31:0] seg, input logic [31:0] va, input bit h);
    return {1'b1, seg[23:0], h, va[27:22]};
  endfunction

  task automatic set_seg(input int s, input logic [31:0] v);
    seg_regs[32*s +: 32] = v;
  endtask

  task automatic run(input logic [31:0] a, input bit w, input bit f, input bit u);
    int n;
    @(negedge clk);
    ea = a; is_write = w; is_fetch = f; user_mode = u; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) chk("R11 done timeout", 1, 0);
  endtask

  localparam logic [31:0] SEG_K0 = 32'h0001_2345;
  localparam logic [31:0] VA     = 32'h3ABC_D123;

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 mem_req", mem_req, 0);
  endtask

  task automatic t_primary_read;
    logic [31:0] g; int r0, w0;
    mem.delete(); set_seg(3, SEG_K0); tbl_desc = 32'h0010_0000;
    g = grp_of(SEG_K0, VA, tbl_desc, 0);
    mem[g] = {tag_of(SEG_K0, VA, 0), 32'h0055_5002};
    r0 = rd_cnt; w0 = wr_cnt;
    run(VA, 0, 0, 0);
    chk("R9 status hit", status, 0);
    chk("R9 phys", phys_addr, 32'h0055_5123);
    chk("R7 key0 pp10 rd", perm_rd, 1);
    chk("R7 key0 pp10 wr", perm_wr, 1);
    chk("R4 reads first slot", rd_cnt - r0, 1);
    chk("R10 one write", wr_cnt - w0, 1);
    chk("R10 write addr", last_wa, g + 4);
    chk("R10 ref set", last_wd, 32'h0055_5102);
  endtask

  task automatic t_primary_late_write;
    logic [31:0] g; int r0;
    mem.delete(); set_seg(3, SEG_K0); tbl_desc = 32'h0010_0000;
    g = grp_of(SEG_K0, VA, tbl_desc, 0);
    mem[g]      = {tag_of(SEG_K0, VA, 0) & 32'h7FFF_FFFF, 32'h0011_1000};
    mem[g + 8]  = {tag_of(SEG_K0, VA, 1), 32'h0022_2000};
    mem[g + 40] = {tag_of(SEG_K0, VA, 0), 32'h0077_7101};
    r0 = rd_cnt;
    run(VA, 1, 0, 0);
    chk("R5 skips invalid and wrong pass", phys_addr, 32'h0077_7123);
    chk("R5 status", status, 0);
    chk("R4 reads to slot 5", rd_cnt - r0, 6);
    chk("R10 write addr slot 5", last_wa, g + 44);
    chk("R10 changed set", last_wd, 32'h0077_7181);
  endtask

  task automatic t_no_rewrite;
    logic [31:0] g; int w0;
    mem.delete(); set_seg(3, SEG_K0); tbl_desc = 32'h0010_0000;
    g = grp_of(SEG_K0, VA, tbl_desc, 0);
    mem[g] = {tag_of(SEG_K0, VA, 0), 32'h0033_3100};
    w0 = wr_cnt;
    run(VA, 0, 0, 0);
    chk("R10 no write when unchanged", wr_cnt - w0, 0);
    chk("R9 hit", status, 0);
  endtask

  task automatic t_secondary;
    logic [31:0] g2; int r0;
    mem.delete(); set_seg(3, SEG_K0); tbl_desc = 32'h0010_0000;
    g2 = grp_of(SEG_K0, VA, tbl_desc, 1);
    mem[g2]      = {tag_of(SEG_K0, VA, 0), 32'h0044_4000};
    mem[g2 + 16] = {tag_of(SEG_K0, VA, 1), 32'h0066_6002};
    r0 = rd_cnt;
    run(VA, 0, 0, 0);
    chk("R6 secondary hit", status, 0);
    chk("R6 secondary phys", phys_addr, 32'h0066_6123);
    chk("R6 reads 8 plus 3", rd_cnt - r0, 11);
  endtask

  task automatic t_not_found;
    int r0;
    mem.delete(); set_seg(3, SEG_K0); tbl_desc = 32'h0010_0000;
    r0 = rd_cnt;
    run(VA, 0, 0, 0);
    chk("R8 not found", status, 1);
    chk("R8 both groups scanned", rd_cnt - r0, 16);
    chk("R8 no perm", {perm_rd, perm_wr}, 0);
  endtask

  task automatic t_prot_key1;
    logic [31:0] s, g; int w0;
    s = 32'h2001_2345;
    mem.delete(); set_seg(3, s); tbl_desc = 32'h0010_0000;
    g = grp_of(s, VA, tbl_desc, 0);
    mem[g] = {tag_of(s, VA, 0), 32'h0012_3000};
    w0 = wr_cnt;
    run(VA, 0, 0, 1);
    chk("R7 key1 pp00 read denied", status, 2);
    chk("R8 no write on denial", wr_cnt - w0, 0);
    mem[g] = {tag_of(s, VA, 0), 32'h0012_3001};
    run(VA, 1, 0, 1);
    chk("R7 key1 pp01 write denied", status, 2);
    mem[g] = {tag_of(s, VA, 0), 32'h0012_3103};
    run(VA, 0, 0, 1);
    chk("R7 key1 pp11 read ok", status, 0);
    chk("R7 key1 pp11 perms", {perm_rd, perm_wr}, 2'b10);
    run(VA, 0, 0, 0);
    chk("R7 seg bit29 supervisor key0 pp11", {perm_rd, perm_wr}, 2'b10);
    mem[g] = {tag_of(s, VA, 0), 32'h0012_3100};
    run(VA, 0, 0, 0);
    chk("R7 key0 pp00 read/write", {perm_rd, perm_wr}, 2'b11);
  endtask

  task automatic t_prot_key0_write;
    logic [31:0] g;
    mem.delete(); set_seg(3, SEG_K0); tbl_desc = 32'h0010_0000;
    g = grp_of(SEG_K0, VA, tbl_desc, 0);
    mem[g] = {tag_of(SEG_K0, VA, 0), 32'h0012_3103};
    run(VA, 1, 0, 0);
    chk("R7 key0 pp11 write denied", status, 2);
  endtask

  task automatic t_key_bit30;
    logic [31:0] s, g;
    s = 32'h4001_2345;
    mem.delete(); set_seg(3, s); tbl_desc = 32'h0010_0000;
    g = grp_of(s, VA, tbl_desc, 0);
    mem[g] = {tag_of(s, VA, 0), 32'h0012_3100};
    run(VA, 0, 0, 0);
    chk("R7 seg bit30 supervisor key1 pp00", status, 2);
    run(VA, 0, 0, 1);
    chk("R7 seg bit30 user key0 pp00", status, 0);
  endtask

  task automatic t_noexec;
    int r0;
    mem.delete(); set_seg(5, 32'h1001_2345);
    r0 = rd_cnt;
    run(32'h5000_0000, 0, 1, 0);
    chk("R3 no-execute", status, 3);
    chk("R3 no reads", rd_cnt - r0, 0);
    run(32'h5000_0000, 0, 0, 0);
    chk("R3 data access proceeds", status, 1);
  endtask

  task automatic t_direct;
    int r0;
    set_seg(8, 32'h9001_2345);
    r0 = rd_cnt;
    run(32'h8123_4567, 0, 1, 0);
    chk("R2 direct store", status, 4);
    chk("R2 no reads", rd_cnt - r0, 0);
  endtask

  task automatic t_mask;
    logic [31:0] g;
    mem.delete(); set_seg(3, SEG_K0); tbl_desc = 32'h0020_0003;
    g = grp_of(SEG_K0, VA, tbl_desc, 0);
    chk("R4 mask widens group", g[17:16] != 2'b00, 1);
    mem[g] = {tag_of(SEG_K0, VA, 0), 32'h0088_8102};
    run(VA, 0, 0, 0);
    chk("R4 sized table hit", phys_addr, 32'h0088_8123);
  endtask

  task automatic t_start_busy;
    logic [31:0] g;
    mem.delete(); set_seg(3, SEG_K0); set_seg(8, 32'h8000_0000);
    tbl_desc = 32'h0010_0000;
    g = grp_of(SEG_K0, VA, tbl_desc, 1);
    mem[g] = {tag_of(SEG_K0, VA, 1), 32'h0099_9100};
    @(negedge clk);
    ea = VA; is_write = 0; is_fetch = 0; user_mode = 0; start = 1'b1;
    @(negedge clk);
    ea = 32'h8000_0000;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R11 start ignored while busy", status, 0);
    chk("R11 phys", phys_addr, 32'h0099_9123);
    @(negedge clk);
    chk("R11 done pulse", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_primary_read();
    t_primary_late_write();
    t_no_rewrite();
    t_secondary();
    t_not_found();
    t_prot_key1();
    t_prot_key0_write();
    t_key_bit30();
    t_noexec();
    t_direct();
    t_mask();
    t_start_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule